// File: doc/BRIEF.md
# Calendar Time-of-Year Counter with Alarms

This block keeps a calendar date and time of day as packed fields (month, day, hour, minute, second and tenths of a second) plus a separate year count. A one-cycle `tick` input, pulsed every tenth of a second by the surrounding logic, moves the time forward. Carries run through all the fields. Day wrapping follows a fixed month-length table with no leap years. Software reaches the block through a 32-bit word-addressed register port. It can load the time word and the year, read both back, program three alarm words and write a control word.

Each alarm word holds a packed target date and time. An alarm fires once, at the tick that moves the running time onto its target second with tenths at zero. The alarm's year field is compared against only the low six bits of the running year. An alarm word of zero is disabled. A parameter selects the interrupt style. In level style, an alarm stays pending until its register is rewritten. In pulse style, a firing raises `irq` for one cycle. The control word gates both counting and alarms with an oscillator bit and a calendar enable bit.

Top module: `toy_calendar`

## Requirements
- R1: After reset the time word reads 0x04200000 (month 1, day 1, all else 0), and the year reads 0. All three alarm words and the control word read 0, and `irq` is low.
- R2: A write to 0x24 loads the time word, and 0x2C reads it back. The time word holds month in [31:26], day in [25:21], hour in [20:16], minute in [15:10], second in [9:4] and tenths in [3:0]. A write to 0x28 loads the year from wdata[YEAR_W-1:0], and 0x30 reads it zero-extended.
- R3: A tick advances the time only while control bit 8 (oscillator) and bit 11 (calendar enable) are both set. Otherwise the time and year hold.
- R4: On each advance, tenths at or above 9 wrap to 0 and carry into seconds. Seconds and minutes at or above 59 wrap to 0 and carry onward, and hours at or above 23 wrap to 0 and carry into the day.
- R5: Month lengths are February 28; April, June, September and November 30; every other month value 31. A day at or above its month length wraps to 1 and carries into the month. A month at or above 12 wraps to 1 and increments the year.
- R6: Three alarm words sit at 0x34, 0x38 and 0x3C and read back as written. Each holds year-low-6 in [31:26], month in [25:22], day in [21:17], hour in [16:12], minute in [11:6] and second in [5:0]. Any of the three can raise `irq`.
- R7: An alarm fires when an advance produces a time whose tenths are 0 and whose second, minute, hour, day and month equal the alarm fields, and whose year's low six bits equal the alarm year field.
- R8: An alarm word of zero never fires.
- R9: While bit 8 or bit 11 of the control word is clear, no alarm fires.
- R10: In level style (IRQ_LEVEL=1), an alarm stays pending once fired, and `irq` is the OR of the pending flags. Further ticks leave it pending. Writing that alarm's register clears its pending flag.
- R11: A write to 0x40 stores all 32 bits whatever their value, and 0x40 reads them back.
- R12: Writes to any other address, including ones that are not word-aligned, change nothing. Reads of unmapped addresses return 0.
- R13: A time or year load in the same cycle as a tick wins, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Tenth-of-a-second step enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its defaults: level-style interrupts, a 16-bit year and three alarms. The 16-bit year lets year carries cross the six-bit alarm boundary, which exposes the partial year compare. The level style keeps every firing observable until the alarm is rewritten, so a reference model can track each pending flag. Randomized loads placed just before minute, day, month and year rollovers bring every carry path into reach within a few ticks.

// File: rtl/toy_pkg.sv
// Shared field layouts, register offsets and the month-length table
// for the calendar counter. Assumes 32-bit registers.
package toy_pkg;

    localparam int WORD_W     = 32;
    localparam int OFS_TOD_LD = 'h24;
    localparam int OFS_YR_LD  = 'h28;
    localparam int OFS_TOD_RD = 'h2C;
    localparam int OFS_YR_RD  = 'h30;
    localparam int OFS_ALM0   = 'h34;
    localparam int OFS_CTRL   = 'h40;
    localparam int CTL_OSC    = 8;
    localparam int CTL_CAL    = 11;

    // Running time word: 6+5+5+6+6+4 = 32 bits
    typedef struct packed {
        logic [5:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [3:0] tenth;
    } tod_t;

    // Alarm word: 6+4+5+5+6+6 = 32 bits
    typedef struct packed {
        logic [5:0] yr6;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } alarm_t;

    // Fixed month lengths, no leap years; unknown months count as 31
    function automatic logic [4:0] month_len(input logic [5:0] m);
        case (m)
            6'd2:                      return 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/toy_time_core.sv
// Time-of-day and year register with the full carry chain.
// Loads win over a step; 'step' must already be gated by the enables.
module toy_time_core
    import toy_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld_tod,
    input  tod_t              tod_in,
    input  logic              ld_year,
    input  logic [YEAR_W-1:0] year_in,
    output tod_t              tod_q,
    output logic [YEAR_W-1:0] year_q,
    output tod_t              tod_nxt,
    output logic [YEAR_W-1:0] year_nxt
);

    // Next value after one tenth-second step, carries rippling upward
    always_comb begin
        tod_nxt  = tod_q;
        year_nxt = year_q;
        if (tod_q.tenth >= 4'd9) begin
            tod_nxt.tenth = '0;
            if (tod_q.sec >= 6'd59) begin
                tod_nxt.sec = '0;
                if (tod_q.min >= 6'd59) begin
                    tod_nxt.min = '0;
                    if (tod_q.hour >= 5'd23) begin
                        tod_nxt.hour = '0;
                        if (tod_q.day >= month_len(tod_q.mon)) begin
                            tod_nxt.day = 5'd1;
                            if (tod_q.mon >= 6'd12) begin
                                tod_nxt.mon = 6'd1;
                                year_nxt    = year_q + 1'b1;
                            end else begin
                                tod_nxt.mon = tod_q.mon + 1'b1;
                            end
                        end else begin
                            tod_nxt.day = tod_q.day + 1'b1;
                        end
                    end else begin
                        tod_nxt.hour = tod_q.hour + 1'b1;
                    end
                end else begin
                    tod_nxt.min = tod_q.min + 1'b1;
                end
            end else begin
                tod_nxt.sec = tod_q.sec + 1'b1;
            end
        end else begin
            tod_nxt.tenth = tod_q.tenth + 1'b1;
        end
    end

    // Time word register: reset to Jan 1, load, or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q     <= '0;
            tod_q.mon <= 6'd1;
            tod_q.day <= 5'd1;
        end else if (ld_tod) begin
            tod_q <= tod_in;
        end else if (step && !ld_year) begin
            tod_q <= tod_nxt;
        end
    end

    // Year register: reset, load, or carry from December
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= '0;
        end else if (ld_year) begin
            year_q <= year_in;
        end else if (step && !ld_tod) begin
            year_q <= year_nxt;
        end
    end

    p_tenth_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step && !ld_tod && !ld_year && tod_q.tenth >= 4'd9 |=> tod_q.tenth == 4'd0);

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !ld_tod && !ld_year |=> tod_q == $past(tod_q) && year_q == $past(year_q));

    p_day_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && !ld_tod && !ld_year && tod_q.tenth >= 4'd9 && tod_q.sec >= 6'd59 &&
        tod_q.min >= 6'd59 && tod_q.hour >= 5'd23 && tod_q.day >= month_len(tod_q.mon)
        |=> tod_q.day == 5'd1);

endmodule

// File: rtl/toy_alarm_unit.sv
// One alarm comparator with its register and pending flag.
// Compares against the post-step time so it fires on the step itself.
module toy_alarm_unit
    import toy_pkg::*;
#(
    parameter bit IRQ_LEVEL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        adv,
    input  tod_t        tod_nxt,
    input  logic [5:0]  yr6_nxt,
    output alarm_t      alarm_q,
    output logic        pend_q
);

    logic hit;

    // Match on a real step into the target second, zero word disabled
    always_comb begin
        hit = adv && (alarm_q != '0) && (tod_nxt.tenth == 4'd0) &&
              (tod_nxt.sec == alarm_q.sec) && (tod_nxt.min == alarm_q.min) &&
              (tod_nxt.hour == alarm_q.hour) && (tod_nxt.day == alarm_q.day) &&
              (tod_nxt.mon == {2'b00, alarm_q.mon}) && (yr6_nxt == alarm_q.yr6);
    end

    // Alarm word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wr) begin
            alarm_q <= alarm_t'(wdata);
        end
    end

    generate
        if (IRQ_LEVEL) begin : g_level
            // Sticky pending flag, cleared by rewriting the alarm
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else if (wr) begin
                    pend_q <= 1'b0;
                end else if (hit) begin
                    pend_q <= 1'b1;
                end
            end

            p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                pend_q && !wr |=> pend_q);
        end else begin : g_pulse
            // One-cycle pulse per firing
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= hit && !wr;
                end
            end
        end
    endgenerate

    p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(alarm_q) != '0);

endmodule

// File: rtl/toy_calendar.sv
// Calendar time-of-year counter: register decode, control word,
// time core and NUM_ALM alarm units. Word registers, exact addresses.
module toy_calendar
    import toy_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int YEAR_W    = 16,
    parameter int NUM_ALM   = 3,
    parameter bit IRQ_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_TOD_LD = ADDR_W'(OFS_TOD_LD);
    localparam logic [ADDR_W-1:0] A_YR_LD  = ADDR_W'(OFS_YR_LD);
    localparam logic [ADDR_W-1:0] A_TOD_RD = ADDR_W'(OFS_TOD_RD);
    localparam logic [ADDR_W-1:0] A_YR_RD  = ADDR_W'(OFS_YR_RD);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

    logic [31:0]       ctrl_q;
    logic              run, ld_tod, ld_year, adv;
    tod_t              tod_q, tod_nxt;
    logic [YEAR_W-1:0] year_q, year_nxt;
    alarm_t            alm_q [NUM_ALM];
    logic [NUM_ALM-1:0] pend;

    // Write decode and step gating
    always_comb begin
        run     = ctrl_q[CTL_OSC] && ctrl_q[CTL_CAL];
        ld_tod  = wr_en && (addr == A_TOD_LD);
        ld_year = wr_en && (addr == A_YR_LD);
        adv     = tick && run && !ld_tod && !ld_year;
    end

    // Control word, stored whole on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl_q <= wdata;
        end
    end

    toy_time_core #(.YEAR_W(YEAR_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (adv),
        .ld_tod   (ld_tod),
        .tod_in   (tod_t'(wdata)),
        .ld_year  (ld_year),
        .year_in  (wdata[YEAR_W-1:0]),
        .tod_q    (tod_q),
        .year_q   (year_q),
        .tod_nxt  (tod_nxt),
        .year_nxt (year_nxt)
    );

    generate
        for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
            localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(OFS_ALM0 + 4 * g);
            toy_alarm_unit #(.IRQ_LEVEL(IRQ_LEVEL)) u_alm (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (wr_en && addr == A_ALM),
                .wdata   (wdata),
                .adv     (adv),
                .tod_nxt (tod_nxt),
                .yr6_nxt (year_nxt[5:0]),
                .alarm_q (alm_q[g]),
                .pend_q  (pend[g])
            );
        end
    endgenerate

    assign irq = |pend;

    // Read mux; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == A_TOD_RD) rdata = tod_q;
        if (addr == A_YR_RD)  rdata = 32'(year_q);
        if (addr == A_CTRL)   rdata = ctrl_q;
        for (int i = 0; i < NUM_ALM; i++) begin
            if (addr == ADDR_W'(OFS_ALM0 + 4 * i)) rdata = alm_q[i];
        end
    end

    p_gated_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_q[CTL_OSC] && ctrl_q[CTL_CAL]));

    p_ctrl_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_CTRL |=> ctrl_q == $past(wdata));

    p_load_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_TOD_LD |=> tod_q == $past(wdata));

endmodule

// File: tb/toy_calendar_test.sv
module toy_calendar_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    int unsigned m_mon, m_day, m_hr, m_min, m_sec, m_ten;
    logic [15:0] m_year;
    logic [31:0] m_ctrl;
    logic [31:0] m_alm [3];
    bit          m_pend [3];

    always #2 clk = ~clk;

    toy_calendar uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int unsigned dim(input int unsigned m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tw(input int unsigned mo, d, h, mi, s, t);
        return {mo[5:0], d[4:0], h[4:0], mi[5:0], s[5:0], t[3:0]};
    endfunction

    function automatic logic [31:0] aw(input int unsigned y, mo, d, h, mi, s);
        return {y[5:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    function automatic logic [31:0] m_word();
        return tw(m_mon, m_day, m_hr, m_min, m_sec, m_ten);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_step();
        if (m_ten >= 9) begin
            m_ten = 0;
            if (m_sec >= 59) begin
                m_sec = 0;
                if (m_min >= 59) begin
                    m_min = 0;
                    if (m_hr >= 23) begin
                        m_hr = 0;
                        if (m_day >= dim(m_mon)) begin
                            m_day = 1;
                            if (m_mon >= 12) begin m_mon = 1; m_year = m_year + 1; end
                            else m_mon = m_mon + 1;
                        end else m_day = m_day + 1;
                    end else m_hr = m_hr + 1;
                end else m_min = m_min + 1;
            end else m_sec = m_sec + 1;
        end else m_ten = m_ten + 1;
    endtask

    task automatic m_apply(input bit tk, input bit we, input logic [7:0] a, input logic [31:0] d);
        bit ldt, ldy, adv;
        ldt = we && a == 8'h24;
        ldy = we && a == 8'h28;
        adv = tk && m_ctrl[8] && m_ctrl[11] && !ldt && !ldy;
        if (adv) begin
            m_step();
            for (int k = 0; k < 3; k++) begin
                if (m_alm[k] != 0 && m_ten == 0 && m_sec == m_alm[k][5:0] &&
                    m_min == m_alm[k][11:6] && m_hr == m_alm[k][16:12] &&
                    m_day == m_alm[k][21:17] && m_mon == {2'b00, m_alm[k][25:22]} &&
                    m_year[5:0] == m_alm[k][31:26])
                    m_pend[k] = 1'b1;
            end
        end
        if (we) begin
            case (a)
                8'h24: begin
                    m_mon = d[31:26]; m_day = d[25:21]; m_hr = d[20:16];
                    m_min = d[15:10]; m_sec = d[9:4];   m_ten = d[3:0];
                end
                8'h28: m_year = d[15:0];
                8'h34: begin m_alm[0] = d; m_pend[0] = 1'b0; end
                8'h38: begin m_alm[1] = d; m_pend[1] = 1'b0; end
                8'h3C: begin m_alm[2] = d; m_pend[2] = 1'b0; end
                8'h40: m_ctrl = d;
                default: ;
            endcase
        end
    endtask

    // One clock with the given inputs; model updated and irq checked after the edge
    task automatic cyc(input bit tk, input bit we, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = tk; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        m_apply(tk, we, a, d);
        #1;
        chk("R7 R10 irq", {31'd0, irq}, {31'd0, m_pend[0] | m_pend[1] | m_pend[2]});
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 32'd0);
    endtask

    task automatic chk_time(input string req);
        logic [31:0] v;
        rd(8'h2C, v); chk(req, v, m_word());
        rd(8'h30, v); chk(req, v, {16'd0, m_year});
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h0001_5EED));
        m_mon = 1; m_day = 1; m_hr = 0; m_min = 0; m_sec = 0; m_ten = 0;
        m_year = 0; m_ctrl = 0;
        for (int k = 0; k < 3; k++) begin m_alm[k] = 0; m_pend[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h2C, v); chk("R1 time", v, 32'h0420_0000);
        rd(8'h30, v); chk("R1 year", v, 32'd0);
        rd(8'h34, v); chk("R1 alarm0", v, 32'd0);
        rd(8'h38, v); chk("R1 alarm1", v, 32'd0);
        rd(8'h3C, v); chk("R1 alarm2", v, 32'd0);
        rd(8'h40, v); chk("R1 ctrl", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R3 ticks with enables clear leave the time alone; R8 zero alarms quiet
        ticks(5);
        chk_time("R3 disabled");
        cyc(1'b0, 1'b1, 8'h40, 32'h0000_0800);
        ticks(3);
        chk_time("R3 osc off");
        cyc(1'b0, 1'b1, 8'h40, 32'h0000_0100);
        ticks(3);
        chk_time("R3 cal off");
        cyc(1'b0, 1'b1, 8'h40, 32'h0000_0900);
        ticks(12);
        rd(8'h2C, v); chk("R3 R4 running", v, tw(1, 1, 0, 0, 1, 2));
        chk("R8 zero alarm", {31'd0, irq}, 32'd0);

        // R2 load and read back
        cyc(1'b0, 1'b1, 8'h24, tw(7, 14, 9, 33, 21, 4));
        cyc(1'b0, 1'b1, 8'h28, 32'hABCD_1234);
        rd(8'h2C, v); chk("R2 time", v, tw(7, 14, 9, 33, 21, 4));
        rd(8'h30, v); chk("R2 year", v, 32'h0000_1234);

        // R4 R5 end of year carry
        cyc(1'b0, 1'b1, 8'h24, tw(12, 31, 23, 59, 59, 9));
        cyc(1'b0, 1'b1, 8'h28, 32'h0000_003F);
        ticks(1);
        rd(8'h2C, v); chk("R5 new year", v, tw(1, 1, 0, 0, 0, 0));
        rd(8'h30, v); chk("R5 year carry", v, 32'h0000_0040);
        cyc(1'b0, 1'b1, 8'h24, tw(2, 28, 23, 59, 59, 9));
        ticks(1);
        rd(8'h2C, v); chk("R5 february", v, tw(3, 1, 0, 0, 0, 0));
        cyc(1'b0, 1'b1, 8'h24, tw(4, 29, 23, 59, 59, 9));
        ticks(1);
        rd(8'h2C, v); chk("R5 april 29", v, tw(4, 30, 0, 0, 0, 0));
        cyc(1'b0, 1'b1, 8'h24, tw(5, 3, 10, 59, 59, 9));
        ticks(1);
        rd(8'h2C, v); chk("R4 hour carry", v, tw(5, 3, 11, 0, 0, 0));

        // R13 load wins over a tick in the same cycle
        cyc(1'b1, 1'b1, 8'h24, tw(6, 6, 6, 6, 6, 6));
        rd(8'h2C, v); chk("R13 load wins", v, tw(6, 6, 6, 6, 6, 6));

        // R6 R7 alarms: year low six bits, each register can fire
        cyc(1'b0, 1'b1, 8'h24, tw(3, 5, 10, 20, 30, 5));
        cyc(1'b0, 1'b1, 8'h28, 32'h0000_0047);
        cyc(1'b0, 1'b1, 8'h34, aw(8, 3, 5, 10, 20, 31));
        cyc(1'b0, 1'b1, 8'h38, aw(7, 3, 5, 10, 20, 31));
        rd(8'h38, v); chk("R6 alarm readback", v, aw(7, 3, 5, 10, 20, 31));
        ticks(4);
        chk("R7 before target", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R7 fires year low6", {31'd0, irq}, 32'd1);
        ticks(15);
        chk("R10 level holds", {31'd0, irq}, 32'd1);
        cyc(1'b0, 1'b1, 8'h38, 32'd0);
        chk("R10 cleared by rewrite", {31'd0, irq}, 32'd0);
        cyc(1'b0, 1'b1, 8'h3C, aw(7, 3, 5, 10, 20, 33));
        ticks(10);
        chk("R6 third alarm", {31'd0, irq}, 32'd1);
        cyc(1'b0, 1'b1, 8'h3C, 32'd0);

        // R9 alarm target passes with the calendar disabled
        cyc(1'b0, 1'b1, 8'h34, aw(7, 3, 5, 10, 20, 35));
        cyc(1'b0, 1'b1, 8'h24, tw(3, 5, 10, 20, 34, 9));
        cyc(1'b0, 1'b1, 8'h40, 32'h0000_2100);
        ticks(3);
        chk("R9 no fire when disabled", {31'd0, irq}, 32'd0);
        chk_time("R9 frozen");

        // R11 control stored whole; R12 stray writes ignored
        cyc(1'b0, 1'b1, 8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R11 ctrl", v, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b1, 8'h25, 32'h1234_5678);
        cyc(1'b0, 1'b1, 8'h2C, 32'h1234_5678);
        cyc(1'b0, 1'b1, 8'h36, 32'h1234_5678);
        chk_time("R12 stray writes");
        rd(8'h34, v); chk("R12 alarm intact", v, aw(7, 3, 5, 10, 20, 35));
        rd(8'h44, v); chk("R12 unmapped read", v, 32'd0);
        cyc(1'b0, 1'b1, 8'h34, 32'd0);

        // Randomized phase against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 70) begin
                cyc(1'b1, 1'b0, 8'h00, 32'd0);
            end else if (r < 76) begin
                int unsigned c;
                c = $urandom % 6;
                cyc($urandom % 2 == 0, 1'b1, 8'h40,
                    c == 0 ? 32'h0000_0800 : c == 1 ? 32'h0000_0100 :
                    c == 5 ? $urandom : 32'h0000_2900);
            end else if (r < 82) begin
                int unsigned mo;
                mo = 1 + $urandom % 12;
                cyc($urandom % 2 == 0, 1'b1, 8'h24,
                    tw(mo, dim(mo) - $urandom % 2, 22 + $urandom % 2,
                       58 + $urandom % 2, 57 + $urandom % 3, $urandom % 10));
            end else if (r < 85) begin
                cyc($urandom % 2 == 0, 1'b1, 8'h28, $urandom);
            end else if (r < 95) begin
                int unsigned k;
                k = $urandom % 3;
                cyc($urandom % 2 == 0, 1'b1, 8'h34 + 8'(4 * k),
                    aw(m_year[5:0], m_mon, m_day, m_hr, m_min, (m_sec + 1) % 60));
            end else begin
                cyc(1'b1, 1'b1, 8'h30 + 8'($urandom % 16), $urandom);
            end
            if (i % 40 == 39) chk_time("R4 R5 random time");
        end
        chk_time("R4 R5 final time");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule